// File: doc/BRIEF.md
# Transmit Interrupt Delay Timer

This block decides when a transmit-complete interrupt is raised as the transmit engine writes back descriptors. For every write-back it reads two flags from the descriptor's 8-bit command byte. One flag, report-status, asks for an interrupt. The other, delay-enable, asks for that interrupt to be held off. The block combines these flags with a programmed delay value and an interrupt-enable mask. It then drives a single sticky cause bit and the interrupt line.

A countdown counter holds the pending delay. The counter decrements once per pulse of an externally prescaled tick input, so one count unit is a fixed number of clock cycles. Every delay-enabled descriptor restarts the countdown. A report-status descriptor that lacks delay-enable raises the interrupt at once and drops any countdown in progress. The cause bit stays set until software clears it with a one-cycle clear pulse. The interrupt line is the cause bit gated by the enable mask.

The control core is a two-state machine. In ST_IDLE no countdown runs. In ST_COUNT the counter is live. The transitions are:
- LOAD moves ST_IDLE to ST_COUNT.
- RELOAD keeps ST_COUNT and rewrites the counter.
- TICK keeps ST_COUNT and decrements the counter.
- EXPIRE moves ST_COUNT to ST_IDLE when the last unit elapses.
- CANCEL moves ST_COUNT to ST_IDLE on an immediate interrupt.

Top module: `txirq_delay_timer`

## Requirements
- R1: The command byte is decoded only at bit 7 (delay-enable) and bit 3 (report-status). A write-back with both bits clear has no effect, and all other bits are ignored.
- R2: A write-back with delay-enable set and a nonzero delay D loads the counter with D. The cause bit is set at the clock edge that samples the D-th tick after the load, and not before.
- R3: Any delay-enabled write-back while a countdown runs reloads the counter with the current delay value, whether or not report-status is set. The countdown restarts from that value.
- R4: A write-back with report-status set and delay-enable clear sets the cause bit at the clock edge that samples the write-back.
- R5: Such an immediate interrupt also cancels a running countdown, so later ticks raise nothing.
- R6: A delay-enabled write-back with a programmed delay of zero sets the cause bit at once, like R4.
- R7: When a reload and a countdown expiry fall in the same cycle, the reload wins and no interrupt is raised.
- R8: The cause bit is sticky until a one-cycle clear pulse. If a new interrupt event and a clear arrive in the same cycle, the event wins.
- R9: The interrupt output equals the cause bit ANDed with the enable mask. An expiry while masked sets the cause bit without asserting the output.
- R10: During and after reset the cause bit and the interrupt output are low and no countdown runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Prescaled time-unit pulse, one cycle wide |
| wb_valid_i | input | 1 | A descriptor write-back happens this cycle |
| wb_cmd_i | input | 8 | Command byte of the written-back descriptor |
| delay_i | input | DLY_W (8) | Programmed delay in tick units |
| irq_en_i | input | 1 | Interrupt enable mask |
| cause_clr_i | input | 1 | One-cycle clear of the cause bit |
| irq_o | output | 1 | Transmit interrupt |
| cause_o | output | 1 | Sticky transmit interrupt cause |

## Verification
The cause bit is registered. Every event that sets or clears it therefore shows up one clock edge after the cycle that presents the write-back, tick or clear. The interrupt output follows the cause bit in the same cycle, gated by the mask currently applied. The bench drives each stimulus on a falling edge and samples both outputs two nanoseconds after the next rising edge. Each expected value belongs to exactly that edge, so a countdown of D units is checked as silent on ticks 1 to D-1 and asserted on tick D.

// File: rtl/txirq_pkg.sv
package txirq_pkg;
    localparam int CMD_W   = 8;
    localparam int IDE_BIT = 7;   // delay-enable position, decoded by the neighbour format
    localparam int RS_BIT  = 3;   // report-status position

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_FIRE,
        ACT_LOAD
    } txirq_act_e;

    typedef enum logic {
        ST_IDLE,
        ST_COUNT
    } txirq_state_e;
endpackage

// File: rtl/txirq_cmd_decode.sv
module txirq_cmd_decode
    import txirq_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic                 valid_i,
    input  logic [CMD_W-1:0]     cmd_i,
    input  logic [DLY_W-1:0]     delay_i,
    output txirq_act_e           act_o
);
    always_comb begin
        act_o = ACT_NONE;
        if (valid_i) begin
            if (cmd_i[IDE_BIT]) begin
                act_o = (delay_i == '0) ? ACT_FIRE : ACT_LOAD;
            end else if (cmd_i[RS_BIT]) begin
                act_o = ACT_FIRE;
            end
        end
    end
endmodule

// File: rtl/txirq_countdown.sv
module txirq_countdown
    import txirq_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  txirq_act_e        act_i,
    input  logic [DLY_W-1:0]  delay_i,
    output logic              expire_o,
    output txirq_state_e      state_o,
    output logic [DLY_W-1:0]  cnt_o
);
    localparam logic [DLY_W-1:0] LAST_UNIT = DLY_W'(1);

    txirq_state_e      state_q, state_d;
    logic [DLY_W-1:0]  cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (act_i == ACT_LOAD) begin          // LOAD
                    state_d = ST_COUNT;
                    cnt_d   = delay_i;
                end
            end
            ST_COUNT: begin
                if (act_i == ACT_LOAD) begin          // RELOAD
                    cnt_d = delay_i;
                end else if (act_i == ACT_FIRE) begin // CANCEL
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (tick_i) begin
                    if (cnt_q == LAST_UNIT) begin     // EXPIRE
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else begin                    // TICK
                        cnt_d = cnt_q - LAST_UNIT;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        expire_o = (state_q == ST_COUNT) && tick_i &&
                   (act_i == ACT_NONE) && (cnt_q == LAST_UNIT);
        state_o  = state_q;
        cnt_o    = cnt_q;
    end
endmodule

// File: rtl/txirq_cause_reg.sv
module txirq_cause_reg (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    output logic cause_o
);
    logic cause_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cause_q <= 1'b0;
        end else if (set_i) begin
            cause_q <= 1'b1;
        end else if (clr_i) begin
            cause_q <= 1'b0;
        end
    end

    assign cause_o = cause_q;
endmodule

// File: rtl/txirq_delay_timer.sv
module txirq_delay_timer
    import txirq_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              wb_valid_i,
    input  logic [CMD_W-1:0]  wb_cmd_i,
    input  logic [DLY_W-1:0]  delay_i,
    input  logic              irq_en_i,
    input  logic              cause_clr_i,
    output logic              irq_o,
    output logic              cause_o
);
    txirq_act_e        act_w;
    logic              expire_w;
    logic              fire_w;
    txirq_state_e      st_w;
    logic [DLY_W-1:0]  cnt_w;

    txirq_cmd_decode #(.DLY_W(DLY_W)) u_dec (
        .valid_i (wb_valid_i),
        .cmd_i   (wb_cmd_i),
        .delay_i (delay_i),
        .act_o   (act_w)
    );

    txirq_countdown #(.DLY_W(DLY_W)) u_cd (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .act_i    (act_w),
        .delay_i  (delay_i),
        .expire_o (expire_w),
        .state_o  (st_w),
        .cnt_o    (cnt_w)
    );

    assign fire_w = (act_w == ACT_FIRE) || expire_w;

    txirq_cause_reg u_cause (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (fire_w),
        .clr_i   (cause_clr_i),
        .cause_o (cause_o)
    );

    assign irq_o = cause_o && irq_en_i;
endmodule

// File: rtl/txirq_delay_timer_chk.sv
module txirq_delay_timer_chk
    import txirq_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tick_i,
    input logic              wb_valid_i,
    input logic [CMD_W-1:0]  wb_cmd_i,
    input logic [DLY_W-1:0]  delay_i,
    input logic              cause_clr_i,
    input logic              irq_o,
    input logic              cause_o,
    input txirq_state_e      st_i,
    input logic [DLY_W-1:0]  cnt_i
);
    AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> cause_o); // R9
    AST_RS_IMMEDIATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wb_valid_i && wb_cmd_i[RS_BIT] && !wb_cmd_i[IDE_BIT]) |=> cause_o); // R4
    AST_RS_CANCELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wb_valid_i && wb_cmd_i[RS_BIT] && !wb_cmd_i[IDE_BIT]) |=> (st_i == ST_IDLE)); // R5
    AST_ZERO_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wb_valid_i && wb_cmd_i[IDE_BIT] && delay_i == '0) |=> cause_o); // R6
    AST_RELOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wb_valid_i && wb_cmd_i[IDE_BIT] && delay_i != '0) |=> (cnt_i == $past(delay_i))); // R3
    AST_RELOAD_NO_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wb_valid_i && wb_cmd_i[IDE_BIT] && delay_i != '0 && !cause_o) |=> !cause_o); // R7
    AST_CAUSE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cause_o && !cause_clr_i) |=> cause_o); // R8
    AST_CAUSE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cause_clr_i && !wb_valid_i && !tick_i) |=> !cause_o); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_i == ST_IDLE) |-> (cnt_i == '0)); // R10
endmodule

bind txirq_delay_timer txirq_delay_timer_chk #(.DLY_W(DLY_W)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .wb_valid_i  (wb_valid_i),
    .wb_cmd_i    (wb_cmd_i),
    .delay_i     (delay_i),
    .cause_clr_i (cause_clr_i),
    .irq_o       (irq_o),
    .cause_o     (cause_o),
    .st_i        (st_w),
    .cnt_i       (cnt_w)
);

// File: tb/txirq_delay_timer_tb_top.sv
`timescale 1ns/1ps
module txirq_delay_timer_tb_top;
    localparam int DLY_W = 8;
    localparam int NVEC  = 35;

    // {tick, valid, cmd[8], delay[8], en, clr, exp_cause, exp_irq, req[4]}
    localparam logic [25:0] VEC [NVEC] = '{
        {1'b0,1'b1,8'h08,8'd0,1'b1,1'b0,1'b1,1'b1,4'd4},  // 0  R4 immediate
        {1'b0,1'b0,8'h00,8'd0,1'b1,1'b1,1'b0,1'b0,4'd8},  // 1  R8 clear
        {1'b0,1'b1,8'h88,8'd3,1'b1,1'b0,1'b0,1'b0,4'd2},  // 2  R2 load 3
        {1'b1,1'b0,8'h00,8'd0,1'b1,1'b0,1'b0,1'b0,4'd2},  // 3  R2 tick 1
        {1'b1,1'b0,8'h00,8'd0,1'b1,1'b0,1'b0,1'b0,4'd2},  // 4  R2 tick 2
        {1'b0,1'b0,8'h00,8'd0,1'b1,1'b0,1'b0,1'b0,4'd2},  // 5  R2 no tick
        {1'b1,1'b0,8'h00,8'd0,1'b1,1'b0,1'b1,1'b1,4'd2},  // 6  R2 tick 3 expires
        {1'b0,1'b0,8'h00,8'd0,1'b1,1'b1,1'b0,1'b0,4'd8},  // 7  R8
        {1'b0,1'b1,8'h88,8'd2,1'b1,1'b0,1'b0,1'b0,4'd2},  // 8  R2 load 2
        {1'b1,1'b0,8'h00,8'd0,1'b1,1'b0,1'b0,1'b0,4'd2},  // 9  R2 down to 1
        {1'b1,1'b1,8'h80,8'd2,1'b1,1'b0,1'b0,1'b0,4'd7},  // 10 R7 reload beats expiry
        {1'b1,1'b0,8'h00,8'd0,1'b1,1'b0,1'b0,1'b0,4'd3},  // 11 R3 restarted
        {1'b1,1'b0,8'h00,8'd0,1'b0,1'b0,1'b1,1'b0,4'd9},  // 12 R9 masked expiry
        {1'b0,1'b0,8'h00,8'd0,1'b1,1'b0,1'b1,1'b1,4'd9},  // 13 R9 unmask
        {1'b0,1'b0,8'h00,8'd0,1'b1,1'b1,1'b0,1'b0,4'd8},  // 14 R8
        {1'b0,1'b1,8'h88,8'd5,1'b1,1'b0,1'b0,1'b0,4'd3},  // 15 R3 load 5
        {1'b1,1'b0,8'h00,8'd0,1'b1,1'b0,1'b0,1'b0,4'd3},  // 16 R3
        {1'b0,1'b1,8'h08,8'd0,1'b1,1'b0,1'b1,1'b1,4'd5},  // 17 R5 immediate cancels
        {1'b0,1'b0,8'h00,8'd0,1'b1,1'b1,1'b0,1'b0,4'd8},  // 18 R8
        {1'b1,1'b0,8'h00,8'd0,1'b1,1'b0,1'b0,1'b0,4'd5},  // 19 R5
        {1'b1,1'b0,8'h00,8'd0,1'b1,1'b0,1'b0,1'b0,4'd5},  // 20 R5
        {1'b1,1'b0,8'h00,8'd0,1'b1,1'b0,1'b0,1'b0,4'd5},  // 21 R5
        {1'b1,1'b0,8'h00,8'd0,1'b1,1'b0,1'b0,1'b0,4'd5},  // 22 R5
        {1'b1,1'b0,8'h00,8'd0,1'b1,1'b0,1'b0,1'b0,4'd5},  // 23 R5
        {1'b0,1'b1,8'h88,8'd0,1'b1,1'b0,1'b1,1'b1,4'd6},  // 24 R6 zero delay
        {1'b0,1'b1,8'h08,8'd0,1'b1,1'b1,1'b1,1'b1,4'd8},  // 25 R8 set beats clear
        {1'b0,1'b0,8'h00,8'd0,1'b1,1'b1,1'b0,1'b0,4'd8},  // 26 R8
        {1'b0,1'b1,8'h00,8'd0,1'b1,1'b0,1'b0,1'b0,4'd1},  // 27 R1 no flags
        {1'b0,1'b1,8'h77,8'd1,1'b1,1'b0,1'b0,1'b0,4'd1},  // 28 R1 other bits only
        {1'b1,1'b0,8'h00,8'd0,1'b1,1'b0,1'b0,1'b0,4'd1},  // 29 R1 nothing armed
        {1'b0,1'b1,8'h88,8'd1,1'b1,1'b0,1'b0,1'b0,4'd2},  // 30 R2 load 1
        {1'b1,1'b0,8'h00,8'd0,1'b1,1'b0,1'b1,1'b1,4'd2},  // 31 R2 expires on first tick
        {1'b0,1'b0,8'h00,8'd0,1'b1,1'b1,1'b0,1'b0,4'd8},  // 32 R8
        {1'b0,1'b1,8'h80,8'd0,1'b1,1'b0,1'b1,1'b1,4'd6},  // 33 R6 delay-enable only, zero
        {1'b0,1'b0,8'h00,8'd0,1'b1,1'b1,1'b0,1'b0,4'd8}   // 34 R8
    };

    logic             clk_i = 1'b0;
    logic             rst_ni = 1'b0;
    logic             tick_i = 1'b0;
    logic             wb_valid_i = 1'b0;
    logic [7:0]       wb_cmd_i = '0;
    logic [DLY_W-1:0] delay_i = '0;
    logic             irq_en_i = 1'b0;
    logic             cause_clr_i = 1'b0;
    logic             irq_o;
    logic             cause_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk_i = ~clk_i;

    txirq_delay_timer #(.DLY_W(DLY_W)) dut_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick_i),
        .wb_valid_i  (wb_valid_i),
        .wb_cmd_i    (wb_cmd_i),
        .delay_i     (delay_i),
        .irq_en_i    (irq_en_i),
        .cause_clr_i (cause_clr_i),
        .irq_o       (irq_o),
        .cause_o     (cause_o)
    );

    task automatic check_out(input string req, input logic exp_cause, input logic exp_irq);
        checks++;
        if (cause_o !== exp_cause || irq_o !== exp_irq) begin
            errors++;
            $display("FAIL %s: cause=%b irq=%b expected cause=%b irq=%b",
                     req, cause_o, irq_o, exp_cause, exp_irq);
        end
    endtask

    task automatic apply(input logic tk, input logic vl, input logic [7:0] cmd,
                         input logic [DLY_W-1:0] dly, input logic en, input logic clr);
        @(negedge clk_i);
        tick_i = tk; wb_valid_i = vl; wb_cmd_i = cmd;
        delay_i = dly; irq_en_i = en; cause_clr_i = clr;
        @(posedge clk_i);
        #2;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk_i);
        #2;
        check_out("R10 in reset", 1'b0, 1'b0);
        @(negedge clk_i);
        rst_ni = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            logic [25:0] v;
            v = VEC[i];
            apply(v[25], v[24], v[23:16], v[15:8], v[7], v[6]);
            checks++;
            if (cause_o !== v[5] || irq_o !== v[4]) begin
                errors++;
                $display("FAIL R%0d vector %0d: cause=%b irq=%b expected cause=%b irq=%b",
                         v[3:0], i, cause_o, irq_o, v[5], v[4]);
            end
        end

        // R10: reset in the middle of a countdown drops it
        apply(1'b0, 1'b1, 8'h88, 8'd2, 1'b1, 1'b0);
        apply(1'b1, 1'b0, 8'h00, 8'd0, 1'b1, 1'b0);
        @(negedge clk_i);
        tick_i = 1'b0; wb_valid_i = 1'b0; rst_ni = 1'b0;
        @(posedge clk_i);
        #2;
        check_out("R10 reset mid-count", 1'b0, 1'b0);
        @(negedge clk_i);
        rst_ni = 1'b1;
        for (int k = 0; k < 4; k++) begin
            apply(1'b1, 1'b0, 8'h00, 8'd0, 1'b1, 1'b0);
            check_out("R10 no countdown after reset", 1'b0, 1'b0);
        end

        // R2: longer delay, silent until the last unit
        apply(1'b0, 1'b1, 8'h88, 8'd10, 1'b1, 1'b0);
        for (int k = 1; k < 10; k++) begin
            apply(1'b1, 1'b0, 8'h00, 8'd0, 1'b1, 1'b0);
            apply(1'b0, 1'b0, 8'h00, 8'd0, 1'b1, 1'b0);
        end
        check_out("R2 delay 10 before last tick", 1'b0, 1'b0);
        apply(1'b1, 1'b0, 8'h00, 8'd0, 1'b1, 1'b0);
        check_out("R2 delay 10 at last tick", 1'b1, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule